// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox

This block passes single bytes in both directions between an external host bus and an on-chip slave processor bus. The host writes a byte into an inbound data register, and the slave reads it. The slave writes a byte into an outbound data register, and the host reads it. A status byte shows which side still has unread data. It also shows whether the last host write was a command or a data byte. The slave gets an interrupt request whenever an inbound byte is waiting.

The host side is asynchronous. It has an active-low select, one address line and active-low read and write strobes. All host inputs pass through a synchroniser into the system clock domain. The block then looks for the rising edge of each strobe. It acts on a host write when the write strobe rises with the select low. Slave accesses are single-cycle read and write pulses on the system clock. The slave has a one-bit register select.

The register that the host reads depends only on the address line, with no clock involved. With the address line low the host sees the outbound byte. With the address line high the host sees the status byte. The slave select works the same way: 0 reads the inbound byte, 1 reads the status byte, and a slave write always targets the outbound byte.

Top module: `hostmbx_top`

## Requirements
- R1: After reset, the status byte reads 0x00 from both sides and the slave interrupt is low.
- R2: A host write with select low captures the host data bus into the inbound register. The capture happens on the rising edge of the write strobe. The slave reads the byte at register select 0.
- R3: Every accepted host write copies the host address line into the command/data flag, which is status bit 3 (1 = command, address line high; 0 = data, address line low).
- R4: An accepted host write sets the inbound-full flag (status bit 1). The slave interrupt output is high exactly while this flag is 1.
- R5: A slave read pulse with register select 0 clears the inbound-full flag.
- R6: A slave write pulse loads the outbound register and sets the outbound-full flag (status bit 0). The host reads the outbound byte with the address line low.
- R7: The outbound-full flag is cleared on the rising edge of the host read strobe, when select is low and the address line is low. A host read of the status byte (address line high) leaves the flag unchanged.
- R8: Host strobes while select is high have no effect on data registers or flags.
- R9: If a set and a clear of the same flag act in the same clock cycle, the flag ends up set. This applies to the inbound-full flag and to the outbound-full flag.
- R10: In the status byte, bits 7..4 and bit 2 always read 0. The host reads the status byte with the address line high, and the slave reads it with register select 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_sel_n | input | 1 | Host select, active low |
| host_a0 | input | 1 | Host address line: 0 = data byte, 1 = status/command |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data (outbound byte or status byte) |
| slv_sel | input | 1 | Slave register select: 0 = data, 1 = status |
| slv_rd | input | 1 | Slave read pulse, one cycle |
| slv_wr | input | 1 | Slave write pulse, one cycle |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data (inbound byte or status byte) |
| slv_irq | output | 1 | Interrupt request, high while an inbound byte is waiting |

## Verification
The bench sends the following patterns and checks the result of each:
- Host writes with the address line low and then high. These show that the data is captured and that the command/data flag follows the address line.
- Slave read pulses and slave write pulses. These show that the flags clear and set from the slave side.
- A host read with the address line high and a host read with the address line low. These show that only a read of the outbound byte clears the outbound-full flag.
- Host write and host read strobes with select high. These show that a strobe without select is ignored: the data registers and the flags keep their values.
- A slave pulse placed in exactly the clock cycle in which a synchronised host strobe edge acts, once for each flag. These show that a set wins over a clear in the same cycle.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;
    localparam int DW = 8;

    // status byte bit positions
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;

    typedef struct packed {
        logic [DW-1:0] inb;
        logic [DW-1:0] outb;
        logic          ibf;
        logic          obf;
        logic          cd;
    } mbx_state_t;

    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } edge_state_t;

    function automatic logic [DW-1:0] pack_status(input logic cd, input logic ibf,
                                                  input logic obf);
        logic [DW-1:0] s;
        s         = '0;
        s[ST_CD]  = cd;
        s[ST_IBF] = ibf;
        s[ST_OBF] = obf;
        return s;
    endfunction
endpackage

// File: rtl/hostmbx_sync.sv
module hostmbx_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = async_i;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hostmbx_hostif.sv
module hostmbx_hostif
    import hostmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n_s,
    input  logic          a0_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    output logic          wr_evt,
    output logic          rd_outb_evt
);
    edge_state_t es_d, es_q;

    always_comb begin
        es_d         = es_q;
        es_d.rd_prev = rd_n_s;
        es_d.wr_prev = wr_n_s;
        wr_evt       = wr_n_s && !es_q.wr_prev && !sel_n_s;
        rd_outb_evt  = rd_n_s && !es_q.rd_prev && !sel_n_s && !a0_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '{rd_prev: 1'b1, wr_prev: 1'b1};
        else        es_q <= es_d;
    end
endmodule

// File: rtl/hostmbx_regs.sv
module hostmbx_regs
    import hostmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_evt,
    input  logic          host_a0_s,
    input  logic [DW-1:0] host_din_s,
    input  logic          host_rd_evt,
    input  logic          slv_rd_evt,
    input  logic          slv_wr_evt,
    input  logic [DW-1:0] slv_wdata,
    output mbx_state_t    st
);
    mbx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, sets after: a set in the same cycle wins
        if (slv_rd_evt)  st_d.ibf = 1'b0;
        if (host_rd_evt) st_d.obf = 1'b0;
        if (host_wr_evt) begin
            st_d.inb = host_din_s;
            st_d.cd  = host_a0_s;
            st_d.ibf = 1'b1;
        end
        if (slv_wr_evt) begin
            st_d.outb = slv_wdata;
            st_d.obf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top
    import hostmbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel_n,
    input  logic          host_a0,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    input  logic          slv_sel,
    input  logic          slv_rd,
    input  logic          slv_wr,
    input  logic [DW-1:0] slv_wdata,
    output logic [DW-1:0] slv_rdata,
    output logic          slv_irq
);
    localparam int GW = DW + 4;

    logic [GW-1:0] grp_async, grp_s;
    logic          sel_n_s, a0_s, rd_n_s, wr_n_s;
    logic [DW-1:0] din_s;
    logic          host_wr_evt, host_rd_evt, slv_rd_evt, slv_wr_evt;
    mbx_state_t    st;
    logic [DW-1:0] status;

    assign grp_async = {host_sel_n, host_a0, host_rd_n, host_wr_n, host_din};

    hostmbx_sync #(.W(GW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (grp_async),
        .sync_o  (grp_s)
    );

    assign {sel_n_s, a0_s, rd_n_s, wr_n_s, din_s} = grp_s;

    hostmbx_hostif u_hostif (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_s     (sel_n_s),
        .a0_s        (a0_s),
        .rd_n_s      (rd_n_s),
        .wr_n_s      (wr_n_s),
        .wr_evt      (host_wr_evt),
        .rd_outb_evt (host_rd_evt)
    );

    assign slv_rd_evt = slv_rd && !slv_sel;
    assign slv_wr_evt = slv_wr;

    hostmbx_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_evt (host_wr_evt),
        .host_a0_s   (a0_s),
        .host_din_s  (din_s),
        .host_rd_evt (host_rd_evt),
        .slv_rd_evt  (slv_rd_evt),
        .slv_wr_evt  (slv_wr_evt),
        .slv_wdata   (slv_wdata),
        .st          (st)
    );

    assign status    = pack_status(st.cd, st.ibf, st.obf);
    assign host_dout = host_a0 ? status : st.outb;
    assign slv_rdata = slv_sel ? status : st.inb;
    assign slv_irq   = st.ibf;
endmodule

// File: rtl/hostmbx_chk.sv
module hostmbx_chk
    import hostmbx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          host_a0,
    input logic [DW-1:0] host_dout,
    input logic          slv_irq,
    input logic          host_wr_evt,
    input logic          host_rd_evt,
    input logic          slv_rd_evt,
    input logic          slv_wr_evt,
    input logic          a0_s,
    input mbx_state_t    st
);
    AST_CD_FOLLOWS_A0: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_evt |=> st.cd == $past(a0_s)); // R3
    AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_evt |=> st.ibf && slv_irq); // R4
    AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rd_evt && !host_wr_evt) |=> !st.ibf); // R5
    AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        slv_wr_evt |=> st.obf); // R6
    AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_evt && !slv_wr_evt) |=> !st.obf); // R7
    AST_OBF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_evt && !slv_wr_evt) |=> $stable(st.obf)); // R8
    AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_a0 |-> (host_dout[7:4] == 4'h0 && !host_dout[2]
                     && host_dout[ST_IBF] == slv_irq)); // R10
endmodule

bind hostmbx_top hostmbx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_a0     (host_a0),
    .host_dout   (host_dout),
    .slv_irq     (slv_irq),
    .host_wr_evt (host_wr_evt),
    .host_rd_evt (host_rd_evt),
    .slv_rd_evt  (slv_rd_evt),
    .slv_wr_evt  (slv_wr_evt),
    .a0_s        (a0_s),
    .st          (st)
);

// File: tb/sim_hostmbx_top.sv
`timescale 1ns/1ps
module sim_hostmbx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_din = '0, host_dout;
    logic       slv_sel = 1'b0, slv_rd = 1'b0, slv_wr = 1'b0;
    logic [7:0] slv_wdata = '0, slv_rdata;
    logic       slv_irq;

    always #4 clk = ~clk; // 125 MHz

    hostmbx_top u0 (.*);

    typedef struct {
        string      req;
        int         kind;   // 0 host_dout, 1 slv_rdata, 2 slv_irq
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  go;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;

    // monitor: pops each expected item and compares it with the port
    initial forever begin
        @(go);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = (it.kind == 0) ? host_dout :
                  (it.kind == 1) ? slv_rdata : {7'b0, slv_irq};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int kind, input logic [7:0] exp);
        q.push_back('{req, kind, exp});
        ->go;
        #2;
    endtask

    task automatic host_status(input string req, input logic [7:0] exp);
        host_a0 = 1'b1;
        expect_val(req, 0, exp);
    endtask

    task automatic slv_status(input string req, input logic [7:0] exp);
        slv_sel = 1'b1;
        expect_val(req, 1, exp);
    endtask

    // align: 0 none, 1 slave read pulse in the host event cycle,
    //        2 slave write pulse (wd) in the host event cycle
    task automatic host_cycle(input bit is_wr, input logic sel_n, input logic a0,
                              input logic [7:0] d, input int align, input logic [7:0] wd);
        @(negedge clk);
        host_sel_n = sel_n; host_a0 = a0; host_din = d;
        if (is_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        if (align == 1) begin slv_sel = 1'b0; slv_rd = 1'b1; end
        if (align == 2) begin slv_wdata = wd; slv_wr = 1'b1; end
        @(negedge clk);
        slv_rd = 1'b0; slv_wr = 1'b0;
        repeat (2) @(negedge clk);
        host_sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic slv_read_data();
        @(negedge clk); slv_sel = 1'b0; slv_rd = 1'b1;
        @(negedge clk); slv_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic slv_write(input logic [7:0] d);
        @(negedge clk); slv_wdata = d; slv_wr = 1'b1;
        @(negedge clk); slv_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        host_status("R1 host status after reset", 8'h00);
        slv_status("R1 slave status after reset", 8'h00);
        expect_val("R1 irq after reset", 2, 8'h00);

        host_cycle(1, 1'b0, 1'b0, 8'hA5, 0, 8'h00);
        slv_status("R4 R10 ibf set by data write", 8'h02);
        expect_val("R4 irq follows ibf", 2, 8'h01);
        slv_sel = 1'b0;
        expect_val("R2 inbound data byte", 1, 8'hA5);

        slv_read_data();
        slv_status("R5 ibf cleared by slave read", 8'h00);
        expect_val("R5 irq low", 2, 8'h00);

        host_cycle(1, 1'b0, 1'b1, 8'h3C, 0, 8'h00);
        slv_status("R3 command flag set by a0 high", 8'h0A);
        slv_sel = 1'b0;
        expect_val("R2 command byte captured", 1, 8'h3C);
        slv_read_data();

        host_cycle(1, 1'b1, 1'b0, 8'h77, 0, 8'h00);
        slv_sel = 1'b0;
        expect_val("R8 write without select ignored (data)", 1, 8'h3C);
        slv_status("R8 write without select ignored (flags)", 8'h08);

        slv_write(8'h5A);
        host_status("R6 obf set by slave write", 8'h09);
        host_a0 = 1'b0;
        expect_val("R6 host reads outbound byte", 0, 8'h5A);

        host_cycle(0, 1'b0, 1'b1, 8'h00, 0, 8'h00);
        host_status("R7 status read keeps obf", 8'h09);

        host_cycle(0, 1'b0, 1'b0, 8'h00, 0, 8'h00);
        host_status("R7 data read clears obf", 8'h08);

        slv_write(8'h11);
        host_cycle(0, 1'b1, 1'b0, 8'h00, 0, 8'h00);
        host_status("R8 read without select keeps obf", 8'h09);

        host_cycle(1, 1'b0, 1'b0, 8'h66, 1, 8'h00);
        slv_status("R9 ibf set beats same-cycle clear", 8'h03);
        expect_val("R9 irq stays high", 2, 8'h01);

        host_cycle(0, 1'b0, 1'b0, 8'h00, 2, 8'h22);
        host_status("R9 obf set beats same-cycle clear", 8'h03);
        host_a0 = 1'b0;
        expect_val("R9 new outbound byte", 0, 8'h22);

        done = 1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule